// File: doc/BRIEF.md
# Key-Locked Countdown Watchdog

This block is a countdown watchdog that sits behind a small register file inside a power-management slave. Software reaches it with single-cycle register writes and combinational reads. It loads a 32-bit timeout, split into a low and a high 16-bit half. Setting the run bit starts a countdown that advances on a slow tick. When the count runs out and reset generation is enabled, the block drives a system reset pulse of fixed length and then stops itself.

The load and control registers are guarded. A write to either one takes effect only after a fixed 16-bit key has been written to the lock register. Any other value written to the lock register guards them again. The countdown, and the timing of the reset pulse, advance only on tick cycles when the module-enable and clock-enable inputs are both high.

Top module: `wdt_keyed`

## Requirements
- R1: After reset the block is guarded, both load halves and the control register read 0, the lock register reads 0, and `sys_rst_o` is low.
- R2: A write of 0xE551 to address 0xA0 opens the guard. A write of any other value to 0xA0 closes it. A read of 0xA0 returns 1 in bit 0 while the guard is open and 0 while it is closed, with all other bits 0.
- R3: While the guard is closed, writes to 0x80, 0x84 and 0x88 leave every register and the countdown unchanged. Reads are allowed at all times.
- R4: Address 0x80 holds the low half and 0x84 the high half of the timeout. Address 0x88 keeps only bit 1 (run), bit 2 (new mode) and bit 3 (reset enable), and reads 0 in every other bit. Unmapped addresses read 0.
- R5: When the run bit changes from 0 to 1, the count loads {high, low}. Each active tick then lowers it by one. The tick that finds the count at 1 or 0 is the expiring tick, so a load of N≥1 expires on the N-th active tick.
- R6: A write to either load half while run is 1 reloads the count at once with the new {high, low} value.
- R7: A tick counts as active only when `tick_i`, `mod_en_i` and `clk_en_i` are all high. The countdown and the pulse length do not change on any other cycle.
- R8: If reset enable is 1 at the expiring tick, `sys_rst_o` rises in the next cycle. It stays high for 4 further active ticks, falls after the fourth of them, and at that same edge the run bit clears.
- R9: If reset enable is 0 at expiry, there is no reset pulse. The count holds at 0 and run stays set. Setting reset enable later produces the pulse on the next active tick.
- R10: The new-mode bit is stored and can be read back, and it has no effect on the countdown or on the reset pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register and counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle strobe of the slow timebase |
| mod_en_i | input | 1 | Module enable from the slave's enable register |
| clk_en_i | input | 1 | Clock enable from the slave's enable register |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 12 | Write address |
| wr_data_i | input | 16 | Write data |
| rd_addr_i | input | 12 | Read address |
| rd_data_o | output | 16 | Read data, combinational |
| sys_rst_o | output | 1 | System reset pulse |

## Verification
The hardest case to reach from the ports is a full 32-bit timeout that uses the high half. With one tick every few cycles, such a run would take far too long. The stimulus therefore holds the tick high on every cycle and loads a high half of 1, which gives 65536 active ticks and still fits within the run time. A second hard case is expiry with reset generation disabled, followed by enabling it while the run bit is already set. This tests that the pulse starts from the held zero count without a reload. A behavioural model in the bench follows every register and the count, and compares each read address in rotation and the reset output on every cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   localparam int unsigned ADDR_MIN_W = 12;
   localparam logic [11:0] A_LOAD_LO  = 12'h080;
   localparam logic [11:0] A_LOAD_HI  = 12'h084;
   localparam logic [11:0] A_CTRL     = 12'h088;
   localparam logic [11:0] A_LOCK     = 12'h0A0;
   localparam logic [15:0] OPEN_KEY   = 16'hE551;
   localparam int unsigned CTL_RUN    = 1;
   localparam int unsigned CTL_NEW    = 2;
   localparam int unsigned CTL_RSTEN  = 3;
endpackage

// File: rtl/wdt_guard.sv
module wdt_guard #(
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned REG_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [REG_W-1:0]  wr_data,
   output logic              is_open
);
   import wdt_pkg::*;

   logic hit;
   assign hit = wr_en && (wr_addr == ADDR_W'(A_LOCK));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   is_open <= 1'b0;
      else if (hit) is_open <= (wr_data == REG_W'(OPEN_KEY));
   end

   assert_key_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && wr_data == REG_W'(OPEN_KEY)) |=> is_open);
   assert_guard_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |=> $stable(is_open));
endmodule

// File: rtl/wdt_regfile.sv
module wdt_regfile #(
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned REG_W  = 16,
   localparam int unsigned CNT_W = 2 * REG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [REG_W-1:0]  wr_data,
   input  logic              is_open,
   input  logic              run_clr,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [REG_W-1:0]  rd_data,
   output logic              run,
   output logic              rst_en,
   output logic              reload,
   output logic [CNT_W-1:0]  reload_val
);
   import wdt_pkg::*;

   logic [REG_W-1:0] load_lo, load_hi, lo_nxt, hi_nxt;
   logic             new_mode;
   logic             wr_ok, we_lo, we_hi, we_ctl;

   assign wr_ok  = wr_en && is_open;
   assign we_lo  = wr_ok && (wr_addr == ADDR_W'(A_LOAD_LO));
   assign we_hi  = wr_ok && (wr_addr == ADDR_W'(A_LOAD_HI));
   assign we_ctl = wr_ok && (wr_addr == ADDR_W'(A_CTRL));

   assign lo_nxt     = we_lo ? wr_data : load_lo;
   assign hi_nxt     = we_hi ? wr_data : load_hi;
   assign reload_val = {hi_nxt, lo_nxt};
   assign reload     = (we_ctl && wr_data[CTL_RUN] && !run) || ((we_lo || we_hi) && run);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         load_lo  <= '0;
         load_hi  <= '0;
         run      <= 1'b0;
         new_mode <= 1'b0;
         rst_en   <= 1'b0;
      end else begin
         load_lo <= lo_nxt;
         load_hi <= hi_nxt;
         if (we_ctl) begin
            new_mode <= wr_data[CTL_NEW];
            rst_en   <= wr_data[CTL_RSTEN];
         end
         if (run_clr)     run <= 1'b0;
         else if (we_ctl) run <= wr_data[CTL_RUN];
      end
   end

   always_comb begin
      rd_data = '0;
      if (rd_addr == ADDR_W'(A_LOAD_LO))      rd_data = load_lo;
      else if (rd_addr == ADDR_W'(A_LOAD_HI)) rd_data = load_hi;
      else if (rd_addr == ADDR_W'(A_CTRL)) begin
         rd_data[CTL_RUN]   = run;
         rd_data[CTL_NEW]   = new_mode;
         rd_data[CTL_RSTEN] = rst_en;
      end else if (rd_addr == ADDR_W'(A_LOCK)) rd_data[0] = is_open;
   end

   assert_closed_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !is_open) |=> ($stable(load_lo) && $stable(load_hi) && $stable(new_mode) && $stable(rst_en)));
   assert_run_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
      run_clr |=> !run);
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
   parameter int unsigned CNT_W       = 32,
   parameter int unsigned PULSE_TICKS = 4,
   localparam int unsigned PW         = $clog2(PULSE_TICKS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             act,
   input  logic             run,
   input  logic             rst_en,
   input  logic             reload,
   input  logic [CNT_W-1:0] reload_val,
   output logic             run_clr,
   output logic             sys_rst
);
   logic [CNT_W-1:0] count;
   logic [PW-1:0]    pcnt;
   logic             pulsing, step, at_end, start;

   assign pulsing = (pcnt != '0);
   assign step    = act && !pulsing && run;
   assign at_end  = (count <= CNT_W'(1));
   assign start   = !reload && step && at_end && rst_en;
   assign run_clr = act && (pcnt == PW'(1));
   assign sys_rst = pulsing;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
         pcnt  <= '0;
      end else begin
         if (reload)    count <= reload_val;
         else if (step) count <= at_end ? '0 : count - CNT_W'(1);
         if (act && pulsing) pcnt <= pcnt - PW'(1);
         else if (start)     pcnt <= PW'(PULSE_TICKS);
      end
   end

   assert_count_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!reload && !act) |=> $stable(count));
   assert_pulse_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pulsing && !act) |=> $stable(pcnt));
   assert_pulse_from_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sys_rst) |-> ($past(act) && $past(rst_en)));
   assert_no_pulse_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!pulsing && !rst_en) |=> !sys_rst);
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed #(
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned REG_W       = 16,
   parameter int unsigned PULSE_TICKS = 4,
   localparam int unsigned CNT_W      = 2 * REG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              mod_en_i,
   input  logic              clk_en_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [REG_W-1:0]  wr_data_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [REG_W-1:0]  rd_data_o,
   output logic              sys_rst_o
);
   if (ADDR_W < wdt_pkg::ADDR_MIN_W) begin : g_bad_addr
      $error("wdt_keyed: ADDR_W too small for register map");
   end
   if (REG_W < 16) begin : g_bad_reg
      $error("wdt_keyed: REG_W must hold the 16-bit key");
   end
   if (PULSE_TICKS < 1) begin : g_bad_pulse
      $error("wdt_keyed: PULSE_TICKS must be at least 1");
   end

   logic             is_open, run, rst_en, reload, run_clr, act;
   logic [CNT_W-1:0] reload_val;

   assign act = tick_i && mod_en_i && clk_en_i;

   wdt_guard #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_guard (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .wr_addr(wr_addr_i),
      .wr_data(wr_data_i), .is_open(is_open));

   wdt_regfile #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .wr_addr(wr_addr_i),
      .wr_data(wr_data_i), .is_open(is_open), .run_clr(run_clr),
      .rd_addr(rd_addr_i), .rd_data(rd_data_o), .run(run), .rst_en(rst_en),
      .reload(reload), .reload_val(reload_val));

   wdt_countdown #(.CNT_W(CNT_W), .PULSE_TICKS(PULSE_TICKS)) u_cnt (
      .clk(clk), .rst_n(rst_n), .act(act), .run(run), .rst_en(rst_en),
      .reload(reload), .reload_val(reload_val), .run_clr(run_clr),
      .sys_rst(sys_rst_o));
endmodule

// File: tb/sim_wdt_keyed.sv
module sim_wdt_keyed;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0, men = 1'b1, cen = 1'b1;
   logic        we = 1'b0;
   logic [11:0] wa = '0, ra = '0;
   logic [15:0] wd = '0;
   logic [15:0] rd;
   logic        srst;

   int checks = 0, fails = 0, cycles = 0;
   string phase = "R1";

   logic        m_unl, m_run, m_new, m_rsten;
   logic [15:0] m_lo, m_hi;
   logic [31:0] m_cnt;
   int          m_p;

   always #5 clk = ~clk;

   wdt_keyed u0 (.clk(clk), .rst_n(rst_n), .tick_i(tick), .mod_en_i(men),
      .clk_en_i(cen), .wr_en_i(we), .wr_addr_i(wa), .wr_data_i(wd),
      .rd_addr_i(ra), .rd_data_o(rd), .sys_rst_o(srst));

   function automatic logic [15:0] m_read(input logic [11:0] a);
      case (a)
         12'h080: return m_lo;
         12'h084: return m_hi;
         12'h088: return {12'd0, m_rsten, m_new, m_run, 1'b0};
         12'h0A0: return {15'd0, m_unl};
         default: return 16'd0;
      endcase
   endfunction

   task automatic check(input bit ok, input string tag, input longint act_v, input longint exp_v);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act_v, exp_v);
      end
   endtask

   always @(posedge clk) begin
      bit act, wok, wlo, whi, wct, rel, rclr, strt;
      logic [15:0] lo_n, hi_n;
      if (!rst_n) begin
         m_unl = 0; m_run = 0; m_new = 0; m_rsten = 0;
         m_lo = 0; m_hi = 0; m_cnt = 0; m_p = 0;
      end else begin
         act  = tick && men && cen;
         wok  = we && m_unl;
         wlo  = wok && wa == 12'h080;
         whi  = wok && wa == 12'h084;
         wct  = wok && wa == 12'h088;
         lo_n = wlo ? wd : m_lo;
         hi_n = whi ? wd : m_hi;
         rel  = (wct && wd[1] && !m_run) || ((wlo || whi) && m_run);
         rclr = act && m_p == 1;
         strt = !rel && act && m_p == 0 && m_run && m_cnt <= 1 && m_rsten;
         if (rel) m_cnt = {hi_n, lo_n};
         else if (act && m_p == 0 && m_run) m_cnt = (m_cnt <= 1) ? 32'd0 : m_cnt - 1;
         if (act && m_p != 0) m_p = m_p - 1;
         else if (strt) m_p = 4;
         if (rclr) m_run = 0;
         else if (wct) m_run = wd[1];
         if (wct) begin m_new = wd[2]; m_rsten = wd[3]; end
         m_lo = lo_n; m_hi = hi_n;
         if (we && wa == 12'h0A0) m_unl = (wd == 16'hE551);
      end
      #3;
      check(rd === m_read(ra), phase, rd, m_read(ra));
      check(srst === (m_p != 0), phase, srst, m_p != 0);
   end

   int ridx = 0;
   always @(negedge clk) begin
      case (ridx)
         0: ra <= 12'h080;
         1: ra <= 12'h084;
         2: ra <= 12'h088;
         3: ra <= 12'h0A0;
         default: ra <= 12'h0C0;
      endcase
      ridx <= (ridx == 4) ? 0 : ridx + 1;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 190000) begin
         fails++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   task automatic wr(input logic [11:0] a, input logic [15:0] d);
      @(negedge clk); we = 1'b1; wa = a; wd = d;
      @(negedge clk); we = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick = 1'b1;
         @(negedge clk); tick = 1'b0;
         @(negedge clk);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      phase = "R1"; idle(3); rst_n = 1'b1; idle(10);
      phase = "R3"; wr(12'h080, 16'd5); wr(12'h088, 16'h000E); ticks(4); idle(6);
      phase = "R2"; wr(12'h0A0, 16'hE551); idle(6); wr(12'h0A0, 16'h1AAE); idle(6);
      wr(12'h080, 16'd9); idle(6);
      wr(12'h0A0, 16'hE551); idle(6);
      phase = "R4"; wr(12'h080, 16'd3); wr(12'h084, 16'h0000); wr(12'h088, 16'hFFF1); idle(6);
      phase = "R10"; wr(12'h088, 16'h0004); idle(6);
      phase = "R5"; wr(12'h088, 16'h000A); ticks(3); idle(6);
      phase = "R8"; ticks(6); idle(6);
      phase = "R7"; wr(12'h080, 16'd6); wr(12'h088, 16'h000A);
      men = 1'b0; ticks(8); men = 1'b1; cen = 1'b0; ticks(8); cen = 1'b1; ticks(3);
      phase = "R6"; wr(12'h080, 16'd10); ticks(5); wr(12'h080, 16'd2); ticks(8); idle(6);
      phase = "R9"; wr(12'h080, 16'd2); wr(12'h088, 16'h0002); ticks(6); idle(5);
      wr(12'h088, 16'h000A); ticks(7); idle(5);
      phase = "R10"; wr(12'h080, 16'd3); wr(12'h088, 16'h000E); ticks(9); idle(5);
      phase = "R5"; wr(12'h080, 16'd0); wr(12'h084, 16'd1); wr(12'h088, 16'h000A);
      @(negedge clk); tick = 1'b1;
      idle(65545);
      tick = 1'b0; idle(10);
      phase = "R3"; wr(12'h0A0, 16'h0000); wr(12'h084, 16'd7); wr(12'h088, 16'h000A); ticks(3); idle(6);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule